// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory that answers reads in the same cycle that the address is registered. It stores words of 36 bits. Each word is four byte lanes, and each lane holds 8 data bits and 1 parity bit. Address, command, chip selects and byte-lane write strobes are all registered on the rising clock edge. Write data follows one cycle after its address. Reads and writes may therefore alternate on every cycle without a dead cycle on the shared data bus. The bidirectional bus is split into `din`, `dout` and an output-enable `dout_en`.

A load cycle (`adv` low) starts a new command at a new address. An advance cycle (`adv` high) continues the current command at the next word of a four-word burst. The burst order is either linear or interleaved. A write's data waits in a one-entry pending stage until the next enabled edge, and a read of that address during that time takes the pending bytes. An active-high clock-enable bar (`clk_en_n`) freezes the whole block for as many cycles as it is held.

The address width `ADDR_W` is a parameter. The default is 8 (256 words), which keeps elaboration small. Setting it to 17 gives the full 131072-word organisation.

Top module: `ftsram`

## Requirements
- R1: While `clk_en_n` is 1 at a rising edge, that edge changes no state: the command, burst position and pending write hold, and `dout`/`dout_en` keep their values.
- R2: A load cycle selects the device only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 all hold together. Any other combination is a deselected cycle: no write occurs, the following `din` is ignored and `dout_en` stays 0.
- R3: The data of a write is taken from `din` at the next enabled edge after its address edge. Lane i consists of `din[8i+7:8i]` together with parity `din[32+i]`. Lane i is written only when `lane_wr_n[i]`=0; the other lanes keep their contents.
- R4: Reads are flow-through. After the edge that registers a read, `dout` carries the addressed word during that same cycle, and `dout_en` is 1 when `oe_n` is 0.
- R5: During the data cycle of a write, `dout_en` is 0 whatever the value of `oe_n`.
- R6: `oe_n`=1 forces `dout_en` to 0 combinationally, without a clock edge. Returning `oe_n` to 0 restores `dout_en` the same way.
- R7: With `burst_ilv`=0 at load time, advance cycles address offset (start+k) mod 4 in the low two address bits, where k counts advances since the load. The upper address bits and the command stay fixed.
- R8: With `burst_ilv`=1 at load time, advance cycles address offset start XOR k in the low two address bits.
- R9: A read of an address whose write data has been taken but not yet stored returns the pending bytes for the written lanes and the stored bytes for the others.
- R10: Reset (`rst_n`=0, asynchronous) returns the block to idle: `dout_en`=0, `dout`=0, no pending write.
- R11: An advance cycle that follows a deselected cycle or reset stays deselected.
- R12: Reads and writes can alternate on consecutive cycles with no idle cycle, and every transfer is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en_n | input | 1 | Clock enable, active low; 1 suspends the block |
| addr | input | ADDR_W | Word address, used on load cycles |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles) |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new command |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data: lane data in [31:0], parity in [35:32] |
| dout | output | 36 | Read data, same layout as `din` |
| dout_en | output | 1 | Drive enable for `dout` onto the shared bus |

## Verification
The hardest state to reach is a read that lands on a word whose write data was taken one edge earlier and still sits in the pending stage. The stimulus must also write only some lanes, so that the returned word mixes pending and stored bytes. The bench creates this by writing once to fill all lanes. It then issues a two-lane write followed at once by a read of the same address, and checks each lane's data and parity. A burst write whose last beat is read back on the very next load reaches the same path through the wrapped burst address. A write address edge followed by a suspended edge checks that the pending capture waits for the next enabled edge.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
  localparam int LANES   = 4;
  localparam int LANE_DW = 8;
  localparam int LANE_W  = LANE_DW + 1;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int PAR_LSB = LANES * LANE_DW;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Extract lane i as {parity, data}
  function automatic logic [LANE_W-1:0] lane_of(input logic [WORD_W-1:0] w, input int i);
    return {w[PAR_LSB+i], w[i*LANE_DW +: LANE_DW]};
  endfunction
endpackage

// File: rtl/ftsram_cmd.sv
module ftsram_cmd
  import ftsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              adv,
  input  logic              burst_ilv,
  output op_e               op_q,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  lane_en_q
);
  logic               sel_ok;
  op_e                load_op;
  op_e                burst_op_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] cnt_q;
  logic               ilv_q;
  logic [BURST_W-1:0] off;

  always_comb begin
    sel_ok  = !sel1_n && sel2 && !sel3_n;
    load_op = !sel_ok ? OP_IDLE : (wr_n ? OP_RD : OP_WR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      burst_op_q <= OP_IDLE;
      base_q     <= '0;
      start_q    <= '0;
      cnt_q      <= '0;
      ilv_q      <= 1'b0;
      lane_en_q  <= '0;
    end else if (!clk_en_n) begin
      lane_en_q <= ~lane_wr_n;
      if (adv) begin
        cnt_q <= cnt_q + 1'b1;
        op_q  <= burst_op_q;
      end else begin
        base_q     <= addr;
        start_q    <= addr[BURST_W-1:0];
        cnt_q      <= '0;
        ilv_q      <= burst_ilv;
        op_q       <= load_op;
        burst_op_q <= load_op;
      end
    end
  end

  // Burst offset: linear wraps by addition, interleaved by XOR
  always_comb begin
    if (ilv_q) off = start_q ^ cnt_q;
    else       off = start_q + cnt_q;
  end

  assign cur_addr = {base_q[ADDR_W-1:BURST_W], off};
endmodule

// File: rtl/ftsram_array.sv
module ftsram_array
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wword,
  input  logic [LANES-1:0]  wmask,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] rd_lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[g]) mem[waddr] <= lane_of(wword, g);
    end
    assign rd_lane[g] = mem[raddr];
  end

  always_comb begin
    rword = '0;
    for (int i = 0; i < LANES; i++) begin
      rword[i*LANE_DW +: LANE_DW] = rd_lane[i][LANE_DW-1:0];
      rword[PAR_LSB+i]            = rd_lane[i][LANE_DW];
    end
  end
endmodule

// File: rtl/ftsram_wbuf.sv
module ftsram_wbuf
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LANES-1:0]  lane_en_q,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] arr_word,
  output logic              commit_we,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [WORD_W-1:0] pend_word,
  output logic [LANES-1:0]  pend_mask,
  output logic              pend_v,
  output logic [WORD_W-1:0] rd_word
);
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_word <= '0;
      pend_mask <= '0;
    end else if (!clk_en_n) begin
      pend_v <= (op_q == OP_WR);
      if (op_q == OP_WR) begin
        pend_addr <= cur_addr;
        pend_word <= din;
        pend_mask <= lane_en_q;
      end
    end
  end

  // The pending word is stored at the next enabled edge
  assign commit_we = pend_v && !clk_en_n;
  assign hit       = pend_v && (pend_addr == cur_addr);

  always_comb begin
    rd_word = arr_word;
    for (int i = 0; i < LANES; i++) begin
      if (hit && pend_mask[i]) begin
        rd_word[i*LANE_DW +: LANE_DW] = pend_word[i*LANE_DW +: LANE_DW];
        rd_word[PAR_LSB+i]            = pend_word[PAR_LSB+i];
      end
    end
  end
endmodule

// File: rtl/ftsram.sv
module ftsram
  import ftsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic [3:0]        lane_wr_n,
  input  logic              adv,
  input  logic              burst_ilv,
  input  logic              oe_n,
  input  logic [35:0]       din,
  output logic [35:0]       dout,
  output logic              dout_en
);
  op_e               op_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_en_q;
  logic              commit_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_word;
  logic [LANES-1:0]  pend_mask;
  logic              pend_v;
  logic [WORD_W-1:0] arr_word;
  logic [WORD_W-1:0] rd_word;

  ftsram_cmd #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .addr      (addr),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .wr_n      (wr_n),
    .lane_wr_n (lane_wr_n),
    .adv       (adv),
    .burst_ilv (burst_ilv),
    .op_q      (op_q),
    .cur_addr  (cur_addr),
    .lane_en_q (lane_en_q)
  );

  ftsram_wbuf #(.ADDR_W(ADDR_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .op_q      (op_q),
    .cur_addr  (cur_addr),
    .lane_en_q (lane_en_q),
    .din       (din),
    .arr_word  (arr_word),
    .commit_we (commit_we),
    .pend_addr (pend_addr),
    .pend_word (pend_word),
    .pend_mask (pend_mask),
    .pend_v    (pend_v),
    .rd_word   (rd_word)
  );

  ftsram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (commit_we),
    .waddr (pend_addr),
    .wword (pend_word),
    .wmask (pend_mask),
    .raddr (cur_addr),
    .rword (arr_word)
  );

  // Drivers only on read cycles; write data cycles keep the bus free
  assign dout_en = (op_q == OP_RD) && !oe_n;
  assign dout    = (op_q == OP_RD) ? rd_word : '0;
endmodule

// File: rtl/ftsram_chk.sv
module ftsram_chk
  import ftsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              adv,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              dout_en,
  input op_e               op_q,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              pend_v
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(op_q) && $stable(cur_addr) && $stable(pend_v));

  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && !(!sel1_n && sel2 && !sel3_n)) |=> (op_q == OP_IDLE));

  p_idle_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && op_q == OP_IDLE) |=> !pend_v);

  p_wrdata_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && op_q == OP_WR) |=> pend_v);

  p_no_drive_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WR) |-> !dout_en);

  p_burst_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && op_q != OP_IDLE) |=>
      (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])) && (op_q == $past(op_q)));

  p_adv_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && op_q == OP_IDLE) |=> (op_q == OP_IDLE));
endmodule

bind ftsram ftsram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .adv      (adv),
  .sel1_n   (sel1_n),
  .sel2     (sel2),
  .sel3_n   (sel3_n),
  .dout_en  (dout_en),
  .op_q     (op_q),
  .cur_addr (cur_addr),
  .pend_v   (pend_v)
);

// File: tb/tb_ftsram.sv
module tb_ftsram;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int NV    = 22;

  typedef struct packed {
    logic        adv;
    logic        sel;
    logic        wr;
    logic [3:0]  ln;
    logic [7:0]  a;
    logic [35:0] d;
    logic        xe;
    logic [35:0] xq;
  } vec_t;

  // Each row: command registered at this edge, din for previous write, expected read output
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,4'h0,8'h10,36'h0,           1'b0,36'h0},            // write 0x10 (R12)
    '{1'b0,1'b1,1'b1,4'h0,8'h11,36'h1_A1B2C3D4,  1'b0,36'h0},            // write 0x11, data for 0x10 (R3)
    '{1'b0,1'b1,1'b0,4'hF,8'h10,36'h2_11223344,  1'b1,36'h1_A1B2C3D4},   // read 0x10 right after writes (R4 R12)
    '{1'b0,1'b1,1'b0,4'hF,8'h11,36'h0,           1'b1,36'h2_11223344},   // read 0x11 from pending/array (R9)
    '{1'b0,1'b1,1'b1,4'hA,8'h11,36'h0,           1'b0,36'h0},            // write lanes 0,2 only (R3 R5)
    '{1'b0,1'b1,1'b0,4'hF,8'h11,36'hF_FFFFFFFF,  1'b1,36'h7_11FF33FF},   // read hits partial pending (R9)
    '{1'b0,1'b1,1'b1,4'h0,8'h20,36'h0,           1'b0,36'h0},            // write after read (R12)
    '{1'b0,1'b1,1'b0,4'hF,8'h20,36'h5_0BADF00D,  1'b1,36'h5_0BADF00D},   // full bypass (R9)
    '{1'b0,1'b1,1'b0,4'hF,8'h11,36'h0,           1'b1,36'h7_11FF33FF},   // merged word stored (R3)
    '{1'b0,1'b0,1'b1,4'h0,8'h10,36'h0,           1'b0,36'h0},            // deselected write (R2)
    '{1'b0,1'b1,1'b0,4'hF,8'h10,36'h9_DEADBEEF,  1'b1,36'h1_A1B2C3D4},   // din ignored (R2)
    '{1'b0,1'b1,1'b1,4'h0,8'h42,36'h0,           1'b0,36'h0},            // burst write start 0x42 (R7)
    '{1'b1,1'b1,1'b1,4'h0,8'h00,36'h0_00000042,  1'b0,36'h0},
    '{1'b1,1'b1,1'b1,4'h0,8'h00,36'h0_00000043,  1'b0,36'h0},
    '{1'b1,1'b1,1'b1,4'h0,8'h00,36'h0_00000040,  1'b0,36'h0},            // wrapped to 0x41 next
    '{1'b0,1'b1,1'b0,4'hF,8'h41,36'h0_00000041,  1'b1,36'h0_00000041},   // linear read start 0x41 (R7 R9)
    '{1'b1,1'b1,1'b0,4'hF,8'h00,36'h0,           1'b1,36'h0_00000042},
    '{1'b1,1'b1,1'b0,4'hF,8'h00,36'h0,           1'b1,36'h0_00000043},
    '{1'b1,1'b1,1'b0,4'hF,8'h00,36'h0,           1'b1,36'h0_00000040},
    '{1'b1,1'b1,1'b0,4'hF,8'h00,36'h0,           1'b1,36'h0_00000041},
    '{1'b0,1'b0,1'b0,4'hF,8'h10,36'h0,           1'b0,36'h0},            // deselect (R2)
    '{1'b1,1'b1,1'b0,4'hF,8'h10,36'h0,           1'b0,36'h0}             // advance after deselect (R11)
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n;
  logic [AW-1:0] addr;
  logic          sel1_n, sel2, sel3_n;
  logic          wr_n;
  logic [3:0]    lane_wr_n;
  logic          adv;
  logic          burst_ilv;
  logic          oe_n;
  logic [35:0]   din;
  logic [35:0]   dout;
  logic          dout_en;

  int  vecs = 0;
  int  errs = 0;
  bit  done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ftsram #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .addr(addr),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .adv(adv), .burst_ilv(burst_ilv), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic cmd(input logic a_dv, input logic sel, input logic wr,
                     input logic [3:0] ln, input logic [AW-1:0] a, input logic [35:0] d);
    adv = a_dv; sel1_n = !sel; sel2 = sel; sel3_n = !sel;
    wr_n = !wr; lane_wr_n = ln; addr = a; din = d;
  endtask

  task automatic exp_rd(input string req, input logic [35:0] q);
    chk(dout_en === 1'b1, req, {35'd0, dout_en}, 36'd1);
    chk(dout === q, req, dout, q);
  endtask

  task automatic exp_quiet(input string req);
    chk(dout_en === 1'b0, req, {35'd0, dout_en}, 36'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; oe_n = 1'b0; burst_ilv = 1'b0;
    cmd(1'b0, 1'b0, 1'b0, 4'hF, '0, '0);
    repeat (3) cyc();
    // R10: reset state
    exp_quiet("R10 reset");
    chk(dout === 36'd0, "R10 reset dout", dout, 36'd0);
    rst_n = 1'b1;

    // Table walk: R3 R4 R5 R9 R12 and friends
    for (int i = 0; i < NV; i++) begin
      cmd(VECS[i].adv, VECS[i].sel, VECS[i].wr, VECS[i].ln, VECS[i].a, VECS[i].d);
      cyc();
      chk(dout_en === VECS[i].xe, "R4 R5 R12 table enable", {35'd0, dout_en}, {35'd0, VECS[i].xe});
      if (VECS[i].xe) chk(dout === VECS[i].xq, "R4 R7 R9 table data", dout, VECS[i].xq);
    end

    // R8: interleaved burst from offset 1: 41,40,43,42
    burst_ilv = 1'b1;
    cmd(1'b0, 1'b1, 1'b0, 4'hF, 8'h41, '0); cyc(); exp_rd("R8 ilv k0", 36'h41);
    burst_ilv = 1'b0;
    cmd(1'b1, 1'b1, 1'b0, 4'hF, 8'h00, '0); cyc(); exp_rd("R8 ilv k1", 36'h40);
    cyc(); exp_rd("R8 ilv k2", 36'h43);
    cyc(); exp_rd("R8 ilv k3", 36'h42);

    // R6: asynchronous output enable
    cmd(1'b0, 1'b1, 1'b0, 4'hF, 8'h20, '0); cyc(); exp_rd("R6 base", 36'h5_0BADF00D);
    oe_n = 1'b1; #1; exp_quiet("R6 oe off");
    oe_n = 1'b0; #1;
    chk(dout_en === 1'b1, "R6 oe on", {35'd0, dout_en}, 36'd1);

    // R5 and R1: write 0x30, then a suspended edge with junk on din
    cmd(1'b0, 1'b1, 1'b1, 4'h0, 8'h30, '0); cyc(); exp_quiet("R5 write phase oe low");
    clk_en_n = 1'b1;
    cmd(1'b0, 1'b1, 1'b0, 4'hF, 8'h10, 36'h0_00000BAD); cyc(); exp_quiet("R1 hold write phase");
    clk_en_n = 1'b0;
    cmd(1'b0, 1'b1, 1'b0, 4'hF, 8'h30, 36'h3_CAFE0030); cyc(); exp_rd("R1 data after hold", 36'h3_CAFE0030);
    clk_en_n = 1'b1;
    cmd(1'b0, 1'b1, 1'b1, 4'h0, 8'h20, 36'h0); cyc(); exp_rd("R1 hold read", 36'h3_CAFE0030);
    clk_en_n = 1'b0;
    cmd(1'b0, 1'b1, 1'b0, 4'hF, 8'h20, 36'h0); cyc(); exp_rd("R1 no write while held", 36'h5_0BADF00D);

    // R2: each single inactive select blocks a write
    for (int k = 0; k < 3; k++) begin
      cmd(1'b0, 1'b1, 1'b1, 4'h0, 8'h40, '0);
      if (k == 0) sel1_n = 1'b1;
      if (k == 1) sel2   = 1'b0;
      if (k == 2) sel3_n = 1'b1;
      cyc(); exp_quiet("R2 partial select");
      cmd(1'b0, 1'b1, 1'b0, 4'hF, 8'h40, 36'hF_00000BAD); cyc(); exp_rd("R2 word unchanged", 36'h40);
    end

    // R10 and R11: reset mid-read, then advance stays idle
    cmd(1'b0, 1'b1, 1'b0, 4'hF, 8'h20, '0); cyc(); exp_rd("R4 before reset", 36'h5_0BADF00D);
    rst_n = 1'b0; #1; exp_quiet("R10 async reset");
    chk(dout === 36'd0, "R10 reset dout", dout, 36'd0);
    cyc(); cyc();
    rst_n = 1'b1;
    cmd(1'b1, 1'b1, 1'b0, 4'hF, 8'h20, '0); cyc(); exp_quiet("R11 advance after reset");

    finish_run();
  end
endmodule